// File: doc/BRIEF.md
# Shared-Line Interrupt Entry and Priority Acknowledge Unit

This unit sits between a processor core and a row of peripheral slots that all share one interrupt request line. Any slot, and any extra source that has no channel number, can raise the line. The core reports each instruction boundary. At the first boundary where interrupts are enabled and the line is high, the unit takes the interrupt. It clears the enable, writes the interrupted program counter to word 0 through a small memory port, reads the handler address from word 1, and hands that address to the core as the new program counter.

Later the service routine asks which device interrupted. The unit then runs an acknowledge pass along the slots, starting at the slot closest to the core. A slot that is requesting and able to answer keeps the acknowledge from travelling further and places its channel number on the result. Slot position is therefore the only thing that sets priority. A result of zero tells software that the source does not answer the acknowledge and has to be found by polling.

An enable instruction turns interrupts back on one instruction late, so the instruction that follows it always completes before another interrupt can enter.

Top module: `irq_chain_ctrl`

## Requirements
- R1: `irq_line` is high in the same cycle whenever any bit of `slot_req` or `aux_req` is high, and low otherwise.
- R2: An interrupt is accepted only on a clock edge where `instr_done` is high, the interrupt enable is in effect and `irq_line` is high. After that edge `entry_busy` is high. With no acceptance, `entry_busy` stays low.
- R3: Acceptance clears the interrupt enable. `irq_enabled` reads 0 in the cycle after acceptance and stays 0 until a new enable matures.
- R4: The first memory access of an entry is a write (`mem_we`=1) to address 0, with `cur_pc` as sampled on the accepting edge. The second access is a read (`mem_we`=0) from address 1. The entry makes no other accesses.
- R5: After the read completes, `pc_load` is high for exactly one cycle, with `pc_value` equal to the read data. `entry_busy` falls two cycles after the read completes.
- R6: `mem_req` stays high, with stable `mem_addr`, `mem_we` and `mem_wdata`, until the edge on which `mem_rdy` is high. An access completes on that edge.
- R7: `ien_set` is sampled only together with `instr_done`. The enable comes into effect at the next `instr_done` edge. An interrupt can be accepted at that same edge, and `irq_enabled` reads 1 after it if no acceptance occurs.
- R8: One cycle after an `ack_start` edge, `ack_valid` pulses for one cycle. `ack_data` then holds the channel of the lowest-index slot whose `slot_req` and `slot_resp` are both high, using the inputs sampled on the `ack_start` edge. Slot i's channel is `slot_chan[i*6 +: 6]`.
- R9: Bits 15..6 of `ack_data` are zero. `ack_data` is zero when no slot has both request and response high, even if `aux_req` or non-responding slots hold the line.
- R10: While reset is held low, `irq_enabled`, `entry_busy`, `mem_req`, `pc_load` and `ack_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_req | input | NSLOT | Per-slot interrupt request |
| slot_resp | input | NSLOT | Slot is populated and answers the acknowledge |
| slot_chan | input | NSLOT*CHW | Channel number of each slot, slot 0 in the low bits |
| aux_req | input | 1 | Request from a source that does not answer the acknowledge |
| irq_line | output | 1 | Shared request line |
| instr_done | input | 1 | Current instruction completes on this edge |
| cur_pc | input | AW | Return address offered at the boundary |
| ien_set | input | 1 | The completing instruction is the enable instruction |
| irq_enabled | output | 1 | Interrupt enable state |
| entry_busy | output | 1 | Entry sequence in progress |
| pc_load | output | 1 | Load `pc_value` into the program counter |
| pc_value | output | AW | Handler address fetched from word 1 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_rdy` |
| mem_rdy | input | 1 | Access completes on this edge |
| ack_start | input | 1 | Run an acknowledge pass |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_data | output | DW | Acknowledge result, channel number zero-extended |

## Verification
Two events can fall on the same edge. One is the enable becoming active while a request is already on the line. In that case acceptance has to happen at that very boundary. The bench provokes this by issuing the enable instruction and then completing one more instruction with the line held high, and it compares `entry_busy` against a bench model of the enable state. The other is an acknowledge pass in which several slots request at once, mixed with non-responding slots and the extra source. The bench changes the requests on the negative edge just before the `ack_start` edge, so the chain sees exactly that pattern. It compares `ack_data` with the nearest slot that has both request and response high, or with zero when there is none.

// File: rtl/irq_chain_pkg.sv
// Package: shared definitions for the shared-line interrupt unit.
// Assumes: entry accesses use fixed word addresses 0 (return) and 1 (vector).
package irq_chain_pkg;

    // States of the interrupt entry sequencer
    typedef enum logic [2:0] {
        ENT_IDLE = 3'd0,
        ENT_SAVE = 3'd1,
        ENT_VEC  = 3'd2,
        ENT_LOAD = 3'd3,
        ENT_DONE = 3'd4
    } entry_state_t;

    localparam int RET_WORD = 0;
    localparam int VEC_WORD = 1;

endpackage

// File: rtl/irq_slot_cell.sv
// Module: one link of the acknowledge chain.
// A slot that requests and answers the acknowledge claims it: it stops the
// acknowledge and drives its channel. Any other slot passes it on without delay.
// Assumes: slot_resp is low for empty slots, so they pass the acknowledge on.
module irq_slot_cell #(
    parameter int CHW = 6
) (
    input  logic           ack_in,
    input  logic           req,
    input  logic           resp,
    input  logic [CHW-1:0] chan,
    output logic           ack_out,
    output logic           sel,
    output logic [CHW-1:0] chan_drv
);

    logic claim;

    // Decide whether this slot takes the acknowledge
    always_comb begin
        claim    = req & resp;
        sel      = ack_in & claim;
        ack_out  = ack_in & ~claim;
        chan_drv = sel ? chan : '0;
    end

endmodule

// File: rtl/irq_ack_chain.sv
// Module: acknowledge chain over all slots plus a result register.
// Slot 0 is nearest the core and has the highest priority.
// Assumes: DW > CHW; inputs are sampled on the ack_start edge.
module irq_ack_chain #(
    parameter int NSLOT = 4,
    parameter int CHW   = 6,
    parameter int DW    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ack_start,
    input  logic [NSLOT-1:0]     slot_req,
    input  logic [NSLOT-1:0]     slot_resp,
    input  logic [NSLOT*CHW-1:0] slot_chan,
    output logic                 ack_valid,
    output logic [DW-1:0]        ack_data
);

    localparam int PADW = DW - CHW;

    logic [NSLOT:0]     link;
    logic [NSLOT-1:0]   sel_vec;
    logic [CHW-1:0]     drv [NSLOT];
    logic [CHW-1:0]     chan_bus;

    assign link[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < NSLOT; gi++) begin : g_slot
            irq_slot_cell #(.CHW(CHW)) u_cell (
                .ack_in  (link[gi]),
                .req     (slot_req[gi]),
                .resp    (slot_resp[gi]),
                .chan    (slot_chan[gi*CHW +: CHW]),
                .ack_out (link[gi+1]),
                .sel     (sel_vec[gi]),
                .chan_drv(drv[gi])
            );
        end
    endgenerate

    // Wired-OR of the channel drivers onto the data lines
    always_comb begin
        chan_bus = '0;
        for (int i = 0; i < NSLOT; i++) begin
            chan_bus = chan_bus | drv[i];
        end
    end

    // Capture the chain result one cycle after the acknowledge starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_data  <= '0;
        end else begin
            ack_valid <= ack_start;
            if (ack_start) begin
                ack_data <= {{PADW{1'b0}}, chan_bus};
            end
        end
    end

endmodule

// File: rtl/irq_en_ctrl.sv
// Module: interrupt enable with a one-instruction delay.
// An enable instruction arms the enable. The enable takes effect at the next
// instruction boundary. Acceptance clears both the enable and the arm bit.
// Assumes: en_instr is only meaningful together with instr_done.
module irq_en_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_done,
    input  logic en_instr,
    input  logic accept,
    output logic ien_eff,
    output logic ien_q
);

    logic arm_q;

    // Enable in force at this boundary, including one that matures now
    always_comb begin
        ien_eff = ien_q | (arm_q & instr_done);
    end

    // Track the armed and enabled states
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
            arm_q <= 1'b0;
        end else if (accept) begin
            ien_q <= 1'b0;
            arm_q <= 1'b0;
        end else if (instr_done) begin
            if (arm_q) begin
                ien_q <= 1'b1;
            end
            arm_q <= en_instr;
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
// Module: interrupt entry sequencer.
// At an accepted boundary it saves the return address to word 0, reads the
// handler address from word 1 and presents it as a one-cycle load.
// Assumes: the memory holds mem_rdata valid on the edge where mem_rdy is high.
module irq_entry_seq
    import irq_chain_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_done,
    input  logic          take_ok,
    input  logic [AW-1:0] cur_pc,
    output logic          accept,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rdy,
    output logic          pc_load,
    output logic [AW-1:0] pc_value
);

    localparam logic [AW-1:0] RET_ADDR = AW'(RET_WORD);
    localparam logic [AW-1:0] VEC_ADDR = AW'(VEC_WORD);

    entry_state_t state_q, state_d;
    logic [AW-1:0] ret_q;
    logic [AW-1:0] vec_q;

    // Accept only from idle at an instruction boundary
    always_comb begin
        accept = (state_q == ENT_IDLE) & instr_done & take_ok;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_IDLE: if (accept)  state_d = ENT_SAVE;
            ENT_SAVE: if (mem_rdy) state_d = ENT_VEC;
            ENT_VEC:  if (mem_rdy) state_d = ENT_LOAD;
            ENT_LOAD: state_d = ENT_DONE;
            ENT_DONE: state_d = ENT_IDLE;
            default:  state_d = ENT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Hold the return address taken at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q <= '0;
        end else if (accept) begin
            ret_q <= cur_pc;
        end
    end

    // Capture the handler address when the vector read completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (state_q == ENT_VEC && mem_rdy) begin
            vec_q <= AW'(mem_rdata);
        end
    end

    // Drive the memory port and program counter load from the state
    always_comb begin
        busy      = (state_q != ENT_IDLE);
        mem_req   = (state_q == ENT_SAVE) | (state_q == ENT_VEC);
        mem_we    = (state_q == ENT_SAVE);
        mem_addr  = (state_q == ENT_SAVE) ? RET_ADDR : VEC_ADDR;
        mem_wdata = DW'(ret_q);
        pc_load   = (state_q == ENT_LOAD);
        pc_value  = vec_q;
    end

endmodule

// File: rtl/irq_chain_ctrl.sv
// Module: top of the shared-line interrupt unit.
// Combines the request line, the delayed enable, the entry sequencer and the
// priority acknowledge chain.
// Assumes: instr_done is not raised while entry_busy is high.
module irq_chain_ctrl #(
    parameter int NSLOT = 4,
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int CHW   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSLOT-1:0]     slot_req,
    input  logic [NSLOT-1:0]     slot_resp,
    input  logic [NSLOT*CHW-1:0] slot_chan,
    input  logic                 aux_req,
    output logic                 irq_line,
    input  logic                 instr_done,
    input  logic [AW-1:0]        cur_pc,
    input  logic                 ien_set,
    output logic                 irq_enabled,
    output logic                 entry_busy,
    output logic                 pc_load,
    output logic [AW-1:0]        pc_value,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic [DW-1:0]        mem_rdata,
    input  logic                 mem_rdy,
    input  logic                 ack_start,
    output logic                 ack_valid,
    output logic [DW-1:0]        ack_data
);

    logic ien_eff;
    logic accept;
    logic take_ok;

    // Wired-OR of every request source onto the shared line
    always_comb begin
        irq_line = (|slot_req) | aux_req;
        take_ok  = ien_eff & irq_line;
    end

    irq_en_ctrl u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_done(instr_done),
        .en_instr  (ien_set),
        .accept    (accept),
        .ien_eff   (ien_eff),
        .ien_q     (irq_enabled)
    );

    irq_entry_seq #(.AW(AW), .DW(DW)) u_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_done(instr_done),
        .take_ok   (take_ok),
        .cur_pc    (cur_pc),
        .accept    (accept),
        .busy      (entry_busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rdy   (mem_rdy),
        .pc_load   (pc_load),
        .pc_value  (pc_value)
    );

    irq_ack_chain #(.NSLOT(NSLOT), .CHW(CHW), .DW(DW)) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_start(ack_start),
        .slot_req (slot_req),
        .slot_resp(slot_resp),
        .slot_chan(slot_chan),
        .ack_valid(ack_valid),
        .ack_data (ack_data)
    );

endmodule

// File: rtl/irq_chain_chk.sv
// Module: property checker for irq_chain_ctrl, attached with bind below.
// Assumes: only top-level ports are observed.
module irq_chain_chk #(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CHW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_line,
    input logic          instr_done,
    input logic          irq_enabled,
    input logic          entry_busy,
    input logic          pc_load,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_rdy,
    input logic          ack_start,
    input logic          ack_valid,
    input logic [DW-1:0] ack_data
);

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(entry_busy) |-> $past(instr_done && irq_line)); // R2

    AST_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(entry_busy) |-> !irq_enabled); // R3

    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_busy |-> !mem_req); // R4

    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load); // R5

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata))); // R6

    AST_ACK_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(ack_start)); // R8

    AST_ACK_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (ack_data[DW-1:CHW] == '0)); // R9

endmodule

bind irq_chain_ctrl irq_chain_chk #(.AW(AW), .DW(DW), .CHW(CHW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_line   (irq_line),
    .instr_done (instr_done),
    .irq_enabled(irq_enabled),
    .entry_busy (entry_busy),
    .pc_load    (pc_load),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdy    (mem_rdy),
    .ack_start  (ack_start),
    .ack_valid  (ack_valid),
    .ack_data   (ack_data)
);

// File: tb/irq_chain_ctrl_bench.sv
// Bench for irq_chain_ctrl: random stimulus from a fixed seed plus directed
// corner cases, checked against a bench model of the requirements.
module irq_chain_ctrl_bench;

    localparam int NSLOT = 4;
    localparam int AW    = 16;
    localparam int DW    = 16;
    localparam int CHW   = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NSLOT-1:0]     slot_req = '0;
    logic [NSLOT-1:0]     slot_resp = '0;
    logic [NSLOT*CHW-1:0] slot_chan = '0;
    logic                 aux_req = 1'b0;
    logic                 irq_line;
    logic                 instr_done = 1'b0;
    logic [AW-1:0]        cur_pc = '0;
    logic                 ien_set = 1'b0;
    logic                 irq_enabled;
    logic                 entry_busy;
    logic                 pc_load;
    logic [AW-1:0]        pc_value;
    logic                 mem_req;
    logic                 mem_we;
    logic [AW-1:0]        mem_addr;
    logic [DW-1:0]        mem_wdata;
    logic [DW-1:0]        mem_rdata = '0;
    logic                 mem_rdy = 1'b0;
    logic                 ack_start = 1'b0;
    logic                 ack_valid;
    logic [DW-1:0]        ack_data;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // Bench model of the enable and memory expectations
    bit b_ien = 1'b0;
    bit b_arm = 1'b0;
    logic [AW-1:0] exp_ret = '0;
    logic [DW-1:0] vec_val = '0;
    int acc_idx = 0;
    int wcnt = 0;
    int dly = 0;

    irq_chain_ctrl #(.NSLOT(NSLOT), .AW(AW), .DW(DW), .CHW(CHW)) u_irq_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .slot_req(slot_req), .slot_resp(slot_resp),
        .slot_chan(slot_chan), .aux_req(aux_req), .irq_line(irq_line),
        .instr_done(instr_done), .cur_pc(cur_pc), .ien_set(ien_set),
        .irq_enabled(irq_enabled), .entry_busy(entry_busy), .pc_load(pc_load),
        .pc_value(pc_value), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rdy(mem_rdy), .ack_start(ack_start), .ack_valid(ack_valid),
        .ack_data(ack_data)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_ack(input logic [NSLOT-1:0] rq,
                                               input logic [NSLOT-1:0] rs,
                                               input logic [NSLOT*CHW-1:0] ch);
        for (int i = 0; i < NSLOT; i++) begin
            if (rq[i] && rs[i]) return DW'(ch[i*CHW +: CHW]);
        end
        return '0;
    endfunction

    // Memory model: random latency, checks each access of the entry (R4, R6)
    always @(negedge clk) begin
        if (mem_rdy) begin
            mem_rdy = 1'b0;
            wcnt = 0;
            dly = $urandom % 3;
        end else if (mem_req) begin
            if (wcnt >= dly) begin
                if (acc_idx == 0) begin
                    chk(mem_we == 1'b1 && mem_addr == 0 && mem_wdata == DW'(exp_ret),
                        "R4 save write", {mem_we, 15'd0, mem_wdata}, {1'b1, 15'd0, DW'(exp_ret)});
                end else if (acc_idx == 1) begin
                    chk(mem_we == 1'b0 && mem_addr == 1, "R4 vector read",
                        {mem_we, 15'd0, mem_addr}, 32'd1);
                end else begin
                    chk(1'b0, "R4 extra access", 32'(acc_idx), 32'd2);
                end
                mem_rdata = vec_val;
                mem_rdy = 1'b1;
                acc_idx++;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic set_line(input logic [NSLOT-1:0] rq, input logic [NSLOT-1:0] rs,
                            input bit ax);
        slot_req = rq;
        slot_resp = rs;
        aux_req = ax;
        #1;
        chk(irq_line == ((|rq) | ax), "R1 line", 32'(irq_line), 32'((|rq) | ax));
    endtask

    task automatic rand_chans();
        for (int i = 0; i < NSLOT; i++) begin
            slot_chan[i*CHW +: CHW] = CHW'(1 + ($urandom % 63));
        end
    endtask

    // One instruction boundary, then follow the entry if one is expected
    task automatic do_instr(input logic [AW-1:0] pc, input bit en);
        bit take;
        int loads = 0;
        int guard = 0;
        take = (b_ien || b_arm) && ((|slot_req) || aux_req);
        exp_ret = pc;
        acc_idx = 0;
        vec_val = DW'($urandom);
        instr_done = 1'b1;
        cur_pc = pc;
        ien_set = en;
        @(posedge clk);
        @(negedge clk);
        instr_done = 1'b0;
        ien_set = 1'b0;
        if (take) begin
            b_ien = 1'b0;
            b_arm = 1'b0;
        end else begin
            if (b_arm) b_ien = 1'b1;
            b_arm = en;
        end
        chk(entry_busy == take, "R2/R7 acceptance", 32'(entry_busy), 32'(take));
        chk(irq_enabled == b_ien, "R3/R7 enable state", 32'(irq_enabled), 32'(b_ien));
        if (take) begin
            while (entry_busy && guard < 50) begin
                if (pc_load) begin
                    loads++;
                    chk(pc_value == AW'(vec_val), "R5 handler address",
                        32'(pc_value), 32'(vec_val));
                end
                guard++;
                @(negedge clk);
            end
            chk(loads == 1, "R5 single load", 32'(loads), 32'd1);
            chk(acc_idx == 2, "R4 access count", 32'(acc_idx), 32'd2);
            chk(irq_enabled == 1'b0, "R3 enable stays clear", 32'(irq_enabled), 32'd0);
        end
    endtask

    task automatic do_ack();
        logic [DW-1:0] e;
        e = exp_ack(slot_req, slot_resp, slot_chan);
        ack_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack_start = 1'b0;
        chk(ack_valid == 1'b1, "R8 ack valid", 32'(ack_valid), 32'd1);
        chk(ack_data == e, "R8/R9 ack data", 32'(ack_data), 32'(e));
        @(negedge clk);
        chk(ack_valid == 1'b0, "R8 ack pulse", 32'(ack_valid), 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog", 32'(cyc), 32'd150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rand_chans();
        // R10: reset state
        repeat (3) @(negedge clk);
        chk({irq_enabled, entry_busy, mem_req, pc_load, ack_valid} == 5'b0,
            "R10 reset outputs",
            32'({irq_enabled, entry_busy, mem_req, pc_load, ack_valid}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: request without enable is not accepted
        set_line(4'b0100, 4'b1111, 1'b0);
        do_instr(16'h0100, 1'b0);
        // R7: enable instruction, then a following instruction with the line high
        do_instr(16'h0101, 1'b1);
        do_instr(16'h0102, 1'b0);
        // R8: two requesters, nearer wins
        slot_chan = {6'd40, 6'd30, 6'd20, 6'd10};
        set_line(4'b1010, 4'b1111, 1'b0);
        do_ack();
        // R8: nearest requester does not respond, so the acknowledge passes it
        set_line(4'b0011, 4'b1110, 1'b0);
        do_ack();
        // R9: only the extra source and a non-responding slot request
        set_line(4'b0001, 4'b1110, 1'b1);
        do_ack();
        // R9: no request at all
        set_line(4'b0000, 4'b1111, 1'b0);
        do_ack();
        // R7: enable maturing with aux on the line while enable is off
        do_instr(16'h0200, 1'b1);
        set_line(4'b0000, 4'b0000, 1'b1);
        do_instr(16'h0201, 1'b0);

        // Random phase
        for (int k = 0; k < 500; k++) begin
            logic [NSLOT-1:0] rq;
            logic [NSLOT-1:0] rs;
            for (int i = 0; i < NSLOT; i++) begin
                rq[i] = (($urandom % 4) == 0);
                rs[i] = (($urandom % 5) != 0);
            end
            rand_chans();
            set_line(rq, rs, (($urandom % 8) == 0));
            if (($urandom % 10) < 6) begin
                do_instr(AW'($urandom), (($urandom % 3) == 0));
            end else begin
                do_ack();
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule